// File: doc/BRIEF.md
# Prefetch Request Disposition Unit

This block decides the fate of each prefetch request. It sits between instruction issue and a short load queue. When a request is accepted, the block looks at the function code, the alternate-space flag with its 8-bit space identifier, and the watchpoint-hit flag. The request then takes one of four paths. It can raise an illegal-instruction trap, raise a watchpoint trap, or be dropped without entering the queue. Otherwise it is written into a FIFO queue of `DEPTH` entries.

When an entry reaches the head of the queue, three inputs are examined: translation miss, data-MMU enable and page cacheability. These inputs, together with a no-op mark recorded at issue, decide between two outcomes. The entry is either removed silently or presented downstream as a 32-byte-aligned prefetch request carrying its function code. A prefetch never faults on translation. Address alignment is not checked.

Three counters track activity: requests issued downstream, entries discarded at the head, and requests that trapped.

Top module: `pf_disposition`

## Requirements
- R1: An accepted request with function code 0..4 whose space is acceptable and whose head conditions are clean is presented on `out_valid` with the same `out_fcn` and with `out_addr` equal to the request address with bits [4:0] cleared.
- R2: Function code 5..15 pulses `trap_illegal` in the accept cycle and is never enqueued. This check takes priority over the watchpoint and over the space drop.
- R3: A request with `req_wp_hit=1` that is not illegal pulses `trap_watch` in the accept cycle and is not enqueued. This applies even to function codes 16..31 and to internal spaces.
- R4: When `req_alt=1` and the space is 0x40–0x6F, 0x76 or 0x77, the request pulses `drop`, is not enqueued and causes no output. When `req_alt=0`, `req_asi` has no effect.
- R5: When `req_alt=1` and the space is not one of 0x04, 0x0C, 0x10, 0x11, 0x18, 0x19, 0x80–0x83 or 0x88–0x8B, the entry is enqueued and then discarded at the head without any output.
- R6: Function code 16..31 is enqueued and then discarded at the head without any output.
- R7: While the entry is at the head, `xlat_miss=1`, `mmu_en=0` or `cacheable=0` causes the entry to be discarded with no output.
- R8: Entries leave in order of acceptance. `req_ready` is low while `DEPTH` entries are held. While `out_ready=0`, the head entry stays on `out_valid`/`out_addr` unchanged.
- R9: `cnt_issued` increments per `out_valid&&out_ready` cycle. `cnt_nop` increments per head discard. `cnt_trap` increments per `trap_illegal` or `trap_watch` pulse. Each counter updates at the edge that ends the event cycle.
- R10: During and after reset the queue is empty, `out_valid=0`, `req_ready=1` and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Prefetch request offered |
| req_ready | output | 1 | Request accepted this cycle when high together with valid |
| req_fcn | input | 5 | Prefetch function code |
| req_alt | input | 1 | Alternate-space form |
| req_asi | input | 8 | Address space identifier (used when req_alt=1) |
| req_addr | input | ADDR_W | Virtual address |
| req_wp_hit | input | 1 | Watchpoint matched this address |
| trap_illegal | output | 1 | Illegal-function trap, accept cycle |
| trap_watch | output | 1 | Watchpoint trap, accept cycle |
| drop | output | 1 | Internal-space request filtered, accept cycle |
| xlat_miss | input | 1 | Translation miss for head entry |
| mmu_en | input | 1 | Data MMU enabled |
| cacheable | input | 1 | Head entry's page is cacheable |
| out_valid | output | 1 | Prefetch request to memory side |
| out_ready | input | 1 | Memory side accepts |
| out_addr | output | ADDR_W | Line-aligned address |
| out_fcn | output | 3 | Function code 0..4 |
| cnt_issued | output | CNT_W | Issued prefetch count |
| cnt_nop | output | CNT_W | Head-discard count |
| cnt_trap | output | CNT_W | Trap count |

## Verification
Each result has its own timing:

- Trap and drop pulses are combinational on the accept cycle, so the bench checks them 1 ns after driving, before the edge.
- An enqueued entry reaches the head one edge after acceptance. The bench therefore checks `out_valid`, `out_addr` and `out_fcn` at the following falling edge.
- Counters move at the edge that ends the event cycle and are checked one falling edge later.

The back-pressure test holds `out_ready` low across several cycles to confirm that the head is held and that a fifth request is refused.

// File: rtl/pf_disposition.sv
module pf_disposition #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16,
  parameter int LINE_B = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [4:0]        req_fcn,
  input  logic              req_alt,
  input  logic [7:0]        req_asi,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wp_hit,
  output logic              trap_illegal,
  output logic              trap_watch,
  output logic              drop,
  input  logic              xlat_miss,
  input  logic              mmu_en,
  input  logic              cacheable,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [2:0]        out_fcn,
  output logic [CNT_W-1:0]  cnt_issued,
  output logic [CNT_W-1:0]  cnt_nop,
  output logic [CNT_W-1:0]  cnt_trap
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((1 << LINE_B) - 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [2:0]        fcn_q  [DEPTH];
  logic [DEPTH-1:0]  nop_q;
  logic [PW-1:0]     wr_q, rd_q;
  logic [PW:0]       cnt_q;

  logic accept, illegal_fcn, internal_asi, asi_ok, push, early_nop;
  logic head_vld, late_nop, discard, pop;

  assign req_ready = cnt_q != (PW+1)'(DEPTH);
  assign accept    = req_valid & req_ready;

  assign illegal_fcn  = ~req_fcn[4] & (req_fcn > 5'd4);
  assign internal_asi = (req_asi[7:4] == 4'h4) | (req_asi[7:4] == 4'h5) |
                        (req_asi[7:4] == 4'h6) | (req_asi[7:1] == 7'h3B);
  assign asi_ok = (req_asi == 8'h04) | (req_asi == 8'h0C) |
                  (req_asi[7:1] == 7'h08) | (req_asi[7:1] == 7'h0C) |
                  (req_asi[7:2] == 6'h20) | (req_asi[7:2] == 6'h22);

  assign trap_illegal = accept & illegal_fcn;
  assign trap_watch   = accept & ~illegal_fcn & req_wp_hit;
  assign drop         = accept & ~illegal_fcn & ~req_wp_hit & req_alt & internal_asi;
  assign push         = accept & ~illegal_fcn & ~req_wp_hit & ~(req_alt & internal_asi);
  assign early_nop    = req_fcn[4] | (req_alt & ~asi_ok);

  assign head_vld  = cnt_q != '0;
  assign late_nop  = nop_q[rd_q] | xlat_miss | ~mmu_en | ~cacheable;
  assign discard   = head_vld & late_nop;
  assign out_valid = head_vld & ~late_nop;
  assign pop       = discard | (out_valid & out_ready);
  assign out_addr  = addr_q[rd_q] & ~LINE_MASK;
  assign out_fcn   = fcn_q[rd_q];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_q] <= req_addr;
      fcn_q[wr_q]  <= req_fcn[2:0];
      nop_q[wr_q]  <= early_nop;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q       <= '0;
      rd_q       <= '0;
      cnt_q      <= '0;
      cnt_issued <= '0;
      cnt_nop    <= '0;
      cnt_trap   <= '0;
    end else begin
      if (push) wr_q <= wr_q + PW'(1);
      if (pop)  rd_q <= rd_q + PW'(1);
      cnt_q      <= cnt_q + (PW+1)'(push) - (PW+1)'(pop);
      cnt_issued <= cnt_issued + CNT_W'(out_valid & out_ready);
      cnt_nop    <= cnt_nop + CNT_W'(discard);
      cnt_trap   <= cnt_trap + CNT_W'(trap_illegal | trap_watch);
    end
  end

  // R2
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_illegal, trap_watch, drop}));

  // R2
  illegal_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_illegal |=> cnt_q <= $past(cnt_q));

  // R1
  out_fcn_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_fcn <= 3'd4);

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & ~out_ready & ~xlat_miss & mmu_en & cacheable) |=>
      (head_vld & $stable(out_addr) & $stable(out_fcn)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (PW+1)'(DEPTH));

  // R9
  issue_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & out_ready) |=> cnt_issued == $past(cnt_issued) + CNT_W'(1));

  // R9
  trap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_illegal | trap_watch) |=> cnt_trap == $past(cnt_trap) + CNT_W'(1));
endmodule

// File: tb/tb_pf_disposition.sv
module tb_pf_disposition;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_alt = 0, req_wp_hit = 0;
  logic [4:0] req_fcn = 0;
  logic [7:0] req_asi = 0;
  logic [31:0] req_addr = 0;
  logic xlat_miss = 0, mmu_en = 1, cacheable = 1, out_ready = 1;
  logic req_ready, trap_illegal, trap_watch, drop, out_valid;
  logic [31:0] out_addr;
  logic [2:0] out_fcn;
  logic [15:0] cnt_issued, cnt_nop, cnt_trap;

  int checks = 0, errors = 0;
  int e_iss = 0, e_nop = 0, e_trap = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pf_disposition dut (.*);

  // {fcn, alt, asi, addr, wp, class}; class 0 issue,1 nop,2 illegal,3 watch,4 drop
  localparam int NV = 14;
  localparam logic [49:0] VEC [NV] = '{
    {5'd0,  1'b0, 8'h00, 32'h12345678, 1'b0, 3'd0},
    {5'd4,  1'b1, 8'h80, 32'hABCDEF1F, 1'b0, 3'd0},
    {5'd7,  1'b0, 8'h00, 32'h00000100, 1'b0, 3'd2},
    {5'd15, 1'b0, 8'h00, 32'h00000200, 1'b1, 3'd2},
    {5'd2,  1'b0, 8'h00, 32'h00000300, 1'b1, 3'd3},
    {5'd20, 1'b0, 8'h00, 32'h00000400, 1'b1, 3'd3},
    {5'd1,  1'b1, 8'h45, 32'h00000500, 1'b0, 3'd4},
    {5'd1,  1'b1, 8'h77, 32'h00000600, 1'b0, 3'd4},
    {5'd1,  1'b0, 8'h45, 32'h0000003F, 1'b0, 3'd0},
    {5'd3,  1'b1, 8'h20, 32'h00000700, 1'b0, 3'd1},
    {5'd31, 1'b0, 8'h00, 32'h00000800, 1'b0, 3'd1},
    {5'd3,  1'b1, 8'h8B, 32'hFFFFFFE1, 1'b0, 3'd0},
    {5'd1,  1'b1, 8'h76, 32'h00000900, 1'b1, 3'd3},
    {5'd2,  1'b1, 8'h19, 32'h00000A40, 1'b0, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_counts(input string req);
    chk(cnt_issued == 16'(e_iss), req, cnt_issued, e_iss);
    chk(cnt_nop == 16'(e_nop), req, cnt_nop, e_nop);
    chk(cnt_trap == 16'(e_trap), req, cnt_trap, e_trap);
  endtask

  task automatic drive(input logic [4:0] f, input logic a, input logic [7:0] s,
                       input logic [31:0] ad, input logic w);
    req_valid = 1; req_fcn = f; req_alt = a; req_asi = s; req_addr = ad; req_wp_hit = w;
  endtask

  task automatic late_case(input string req);
    @(negedge clk);
    drive(5'd0, 1'b0, 8'h00, 32'h00004444, 1'b0);
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(out_valid == 0, req, out_valid, 0);
    e_nop++;
    @(negedge clk);
    chk_counts("R9 late");
    xlat_miss = 0; mmu_en = 1; cacheable = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 during reset
    chk(out_valid == 0 && req_ready == 1, "R10", {out_valid, req_ready}, 2'b01);
    chk_counts("R10");
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] cls;
      logic [31:0] ad;
      logic [4:0] f;
      cls = VEC[i][2:0];
      ad = VEC[i][35:4];
      f = VEC[i][49:45];
      @(negedge clk);
      drive(f, VEC[i][44], VEC[i][43:36], ad, VEC[i][3]);
      #1;
      chk(trap_illegal == (cls == 2), "R2 illegal pulse", trap_illegal, cls == 2);
      chk(trap_watch == (cls == 3), "R3 watch pulse", trap_watch, cls == 3);
      chk(drop == (cls == 4), "R4 drop pulse", drop, cls == 4);
      @(posedge clk); #1 req_valid = 0;
      @(negedge clk);
      chk(out_valid == (cls == 0), "R5 R6 out_valid", out_valid, cls == 0);
      if (cls == 0) begin
        chk(out_addr == (ad & 32'hFFFFFFE0), "R1 addr", out_addr, ad & 32'hFFFFFFE0);
        chk(out_fcn == f[2:0], "R1 fcn", out_fcn, f[2:0]);
        e_iss++;
      end
      if (cls == 1) e_nop++;
      if (cls == 2 || cls == 3) e_trap++;
      @(negedge clk);
      chk_counts("R9");
    end

    mmu_en = 0;    late_case("R7 mmu off");
    xlat_miss = 1; late_case("R7 miss");
    cacheable = 0; late_case("R7 noncacheable");

    // R8 back-pressure and order
    out_ready = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      drive(5'(k), 1'b0, 8'h00, 32'h1000 + 32'(k) * 32'h40 + 32'h3, 1'b0);
      @(posedge clk); #1 req_valid = 0;
    end
    @(negedge clk);
    chk(req_ready == 0, "R8 full", req_ready, 0);
    chk(out_addr == 32'h1000, "R8 head", out_addr, 32'h1000);
    drive(5'd0, 1'b0, 8'h00, 32'h00009990, 1'b0);
    @(negedge clk);
    chk(out_valid == 1 && out_addr == 32'h1000, "R8 hold", out_addr, 32'h1000);
    req_valid = 0; out_ready = 1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(out_valid == 1 && out_addr == 32'h1000 + 32'(k) * 32'h40, "R8 order",
          out_addr, 32'h1000 + 32'(k) * 32'h40);
      chk(out_fcn == 3'(k), "R8 fcn", out_fcn, k);
      e_iss++;
      @(negedge clk);
    end
    chk(out_valid == 0, "R8 refused", out_valid, 0);
    chk_counts("R9 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule